// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block decides when a chip leaves its low-power standby state. While the chip runs, a sleep request turns the main clock enable off and stores the chosen oscillator settling period. In standby the block watches a non-maskable interrupt pin, a set of prioritised external interrupt lines and two active-low reset pins. The block runs on an always-on clock.

When a wake interrupt arrives, a settling counter starts. The main clock stays gated until that counter overflows. The block then turns the clock back on and reports what caused the wake, so the exception logic can start the right handler. A reset pin driven low skips the settling counter and enables the clock at once. The block then waits in a reset-hold state until the pin is released. A DMA transfer that is still running when sleep is accepted is cut off, and a one-cycle abort flag reports it.

Top module: `standby_wakeup_seq`

## Requirements
- R1: The reset state is RUN. `sleep_req` sampled high in RUN moves the block to STANDBY, and `clk_en` is low from the next cycle. `clk_en` is high in RUN and in reset-hold, and low in STANDBY and SETTLE. `sleep_req` has no effect in any other state.
- R2: `settle_sel` is captured when sleep is accepted. A value k gives a SETTLE phase of exactly 2^(k+6) clock cycles, after which RUN is re-entered.
- R3: `wake_valid` is a one-cycle pulse in the first cycle back in RUN, and `clk_en` is high in that cycle. `wake_cause` encodes the cause as 0 for NMI, 1 for IRQ, 2 for power-on reset and 3 for manual reset.
- R4: With `nmi_rise`=1 only a rising NMI edge wakes the chip, and with `nmi_rise`=0 only a falling edge does. The opposite edge is ignored. The asynchronous pins pass through two synchronizing flops, so a pin change is acted on at the third rising clock edge after it.
- R5: An IRQ line that is high wakes the chip only when its 4-bit priority is strictly greater than `cpu_mask`. A line whose priority is less than or equal to the mask leaves the chip in standby.
- R6: When several eligible IRQ lines are high, the highest priority wins and a tie goes to the lowest index. `wake_irq_id` reports the winning index.
- R7: When an NMI edge and an eligible IRQ are seen in the same cycle, the wake is reported as NMI.
- R8: `por_n` seen low in STANDBY or SETTLE enters reset-hold without settling, so `clk_en` rises on the next cycle. When both reset pins are high again, RUN is re-entered with cause 2.
- R9: `mres_n` alone behaves in the same way with cause 3. If `por_n` is low at any time during the hold, the cause is 2.
- R10: `dma_abort` pulses for one cycle, the cycle after sleep is accepted, if `dma_busy` was high when sleep was accepted. It stays low at all other times.
- R11: After `rst_n` is released, `clk_en` is 1 and `dma_abort` and `wake_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_req | input | 1 | Request to enter standby |
| dma_busy | input | 1 | A DMA transfer is in progress |
| settle_sel | input | SEL_W | Settling period select |
| nmi_pin | input | 1 | Non-maskable interrupt pin (asynchronous) |
| nmi_rise | input | 1 | 1: rising edge wakes, 0: falling edge wakes |
| irq_pin | input | NIRQ | Level interrupt lines (asynchronous) |
| irq_prio | input | NIRQ*PRIO_W | Priority per line, line i in bits [i*PRIO_W +: PRIO_W] |
| cpu_mask | input | PRIO_W | CPU interrupt mask level |
| por_n | input | 1 | Power-on reset pin, active low |
| mres_n | input | 1 | Manual reset pin, active low |
| clk_en | output | 1 | Main clock enable |
| dma_abort | output | 1 | One-cycle DMA abort pulse |
| wake_valid | output | 1 | One-cycle pulse when standby ends |
| wake_cause | output | 2 | Cause code, valid with wake_valid |
| wake_irq_id | output | ID_W | Winning IRQ index, valid when the cause is IRQ |

## Verification
The bench measures wake latency exactly: from the driven pin change to `wake_valid` it counts three synchronizer and decision edges plus the full settling count. A counter that is off by one, or a select field decoded to the wrong power of two, therefore shows up as a wrong cycle count. It tries an NMI edge of the wrong polarity, and an IRQ whose priority is below the mask and then equal to it. A design that compared the mask with `>=` or ignored the polarity select would wake the chip early. It raises several IRQs at once with tied priorities, and an NMI together with an IRQ, to catch wrong arbitration order. It drives the reset pins during SETTLE and in standby, including both pins at once. A design that sent a reset wake through the counter, released the hold early or lost the power-on cause would enable the clock late or report the wrong code.

// File: rtl/swu_pkg.sv
package swu_pkg;
   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_STANDBY  = 2'd1,
      ST_SETTLE   = 2'd2,
      ST_RST_HOLD = 2'd3
   } swu_state_e;

   typedef enum logic [1:0] {
      WC_NMI  = 2'd0,
      WC_IRQ  = 2'd1,
      WC_POR  = 2'd2,
      WC_MRES = 2'd3
   } wake_cause_e;
endpackage

// File: rtl/swu_sync.sv
module swu_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("swu_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("swu_sync width must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/swu_irq_arb.sv
module swu_irq_arb #(
   parameter int NIRQ          = 4,
   parameter int PRIO_W        = 4,
   parameter int ID_W          = 2,
   parameter bit TIE_LOW_INDEX = 1'b1
) (
   input  logic [NIRQ-1:0]        req,
   input  logic [NIRQ*PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]      mask,
   output logic                   hit,
   output logic [ID_W-1:0]        id
);
   generate
      if (ID_W < 1 || (1 << ID_W) < NIRQ) begin : g_bad_id
         $error("swu_irq_arb id width too small for line count");
      end
   endgenerate

   logic [PRIO_W-1:0] best_p;

   generate
      if (TIE_LOW_INDEX) begin : g_scan_up
         always_comb begin
            hit    = 1'b0;
            id     = '0;
            best_p = '0;
            for (int i = 0; i < NIRQ; i++) begin
               if (req[i] && prio[i*PRIO_W +: PRIO_W] > mask &&
                   (!hit || prio[i*PRIO_W +: PRIO_W] > best_p)) begin
                  hit    = 1'b1;
                  id     = ID_W'(i);
                  best_p = prio[i*PRIO_W +: PRIO_W];
               end
            end
         end
      end else begin : g_scan_down
         always_comb begin
            hit    = 1'b0;
            id     = '0;
            best_p = '0;
            for (int i = NIRQ-1; i >= 0; i--) begin
               if (req[i] && prio[i*PRIO_W +: PRIO_W] > mask &&
                   (!hit || prio[i*PRIO_W +: PRIO_W] > best_p)) begin
                  hit    = 1'b1;
                  id     = ID_W'(i);
                  best_p = prio[i*PRIO_W +: PRIO_W];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/swu_settle_timer.sv
module swu_settle_timer #(
   parameter int SEL_W      = 3,
   parameter int BASE_SHIFT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] sel,
   input  logic             start,
   input  logic             run,
   output logic             done
);
   localparam int MAXSEL = (1 << SEL_W) - 1;
   localparam int CNT_W  = BASE_SHIFT + MAXSEL;
   localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

   generate
      if (CNT_W > 31 || BASE_SHIFT < 1) begin : g_bad_cnt
         $error("swu_settle_timer counter width out of range");
      end
   endgenerate

   logic [CNT_W-1:0] lim_m1_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_m1_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (load) lim_m1_q <= ALL1 >> (MAXSEL - int'(sel));
         if (start)    cnt_q <= '0;
         else if (run) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = run && (cnt_q == lim_m1_q);
endmodule

// File: rtl/standby_wakeup_seq.sv
module standby_wakeup_seq
   import swu_pkg::*;
#(
   parameter int NIRQ          = 4,
   parameter int PRIO_W        = 4,
   parameter int SEL_W         = 3,
   parameter int BASE_SHIFT    = 6,
   parameter int SYNC_STAGES   = 2,
   parameter bit TIE_LOW_INDEX = 1'b1,
   localparam int ID_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sleep_req,
   input  logic                   dma_busy,
   input  logic [SEL_W-1:0]       settle_sel,
   input  logic                   nmi_pin,
   input  logic                   nmi_rise,
   input  logic [NIRQ-1:0]        irq_pin,
   input  logic [NIRQ*PRIO_W-1:0] irq_prio,
   input  logic [PRIO_W-1:0]      cpu_mask,
   input  logic                   por_n,
   input  logic                   mres_n,
   output logic                   clk_en,
   output logic                   dma_abort,
   output logic                   wake_valid,
   output logic [1:0]             wake_cause,
   output logic [ID_W-1:0]        wake_irq_id
);
   generate
      if (NIRQ < 1 || PRIO_W < 1) begin : g_bad_cfg
         $error("standby_wakeup_seq needs at least one IRQ and a priority field");
      end
   endgenerate

   // synchronized views of the asynchronous pins
   logic [NIRQ:0] lvl_s;
   logic [1:0]    rst_s;
   logic          nmi_s, nmi_prev_q;
   logic [NIRQ-1:0] irq_s;

   swu_sync #(.W(NIRQ+1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lvl (
      .clk(clk), .rst_n(rst_n), .d({irq_pin, nmi_pin}), .q(lvl_s));

   swu_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rst (
      .clk(clk), .rst_n(rst_n), .d({mres_n, por_n}), .q(rst_s));

   assign nmi_s = lvl_s[0];
   assign irq_s = lvl_s[NIRQ:1];

   logic por_low, mres_low, rst_any;
   assign por_low  = ~rst_s[0];
   assign mres_low = ~rst_s[1];
   assign rst_any  = por_low | mres_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nmi_prev_q <= 1'b0;
      else        nmi_prev_q <= nmi_s;
   end

   logic nmi_edge;
   assign nmi_edge = nmi_rise ? (nmi_s & ~nmi_prev_q) : (~nmi_s & nmi_prev_q);

   logic            irq_hit;
   logic [ID_W-1:0] irq_win;

   swu_irq_arb #(.NIRQ(NIRQ), .PRIO_W(PRIO_W), .ID_W(ID_W),
                 .TIE_LOW_INDEX(TIE_LOW_INDEX)) u_arb (
      .req(irq_s), .prio(irq_prio), .mask(cpu_mask), .hit(irq_hit), .id(irq_win));

   swu_state_e      state_q;
   wake_cause_e     cause_q;
   logic [ID_W-1:0] id_q;
   logic            wake_q, abort_q;

   logic tmr_load, tmr_start, tmr_run, settle_done;
   assign tmr_load  = (state_q == ST_RUN) && sleep_req;
   assign tmr_start = (state_q == ST_STANDBY) && !rst_any && (nmi_edge || irq_hit);
   assign tmr_run   = (state_q == ST_SETTLE);

   swu_settle_timer #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .sel(settle_sel),
      .start(tmr_start), .run(tmr_run), .done(settle_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cause_q <= WC_NMI;
         id_q    <= '0;
         wake_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         wake_q  <= 1'b0;
         abort_q <= 1'b0;
         unique case (state_q)
            ST_RUN: begin
               if (sleep_req) begin
                  state_q <= ST_STANDBY;
                  abort_q <= dma_busy;
               end
            end
            ST_STANDBY: begin
               if (rst_any) begin
                  state_q <= ST_RST_HOLD;
                  cause_q <= por_low ? WC_POR : WC_MRES;
               end else if (nmi_edge) begin
                  state_q <= ST_SETTLE;
                  cause_q <= WC_NMI;
               end else if (irq_hit) begin
                  state_q <= ST_SETTLE;
                  cause_q <= WC_IRQ;
                  id_q    <= irq_win;
               end
            end
            ST_SETTLE: begin
               if (rst_any) begin
                  state_q <= ST_RST_HOLD;
                  cause_q <= por_low ? WC_POR : WC_MRES;
               end else if (settle_done) begin
                  state_q <= ST_RUN;
                  wake_q  <= 1'b1;
               end
            end
            ST_RST_HOLD: begin
               if (por_low) cause_q <= WC_POR;
               if (!rst_any) begin
                  state_q <= ST_RUN;
                  wake_q  <= 1'b1;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign clk_en      = (state_q == ST_RUN) || (state_q == ST_RST_HOLD);
   assign dma_abort   = abort_q;
   assign wake_valid  = wake_q;
   assign wake_cause  = cause_q;
   assign wake_irq_id = id_q;
endmodule

// File: rtl/swu_chk.sv
module swu_chk #(
   parameter int SEL_W      = 3,
   parameter int BASE_SHIFT = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep_req,
   input logic             dma_busy,
   input logic [SEL_W-1:0] settle_sel,
   input logic             clk_en,
   input logic             dma_abort,
   input logic             wake_valid,
   input logic [1:0]       wake_cause,
   input logic [1:0]       state_q
);
   localparam logic [1:0] S_RUN = 2'd0, S_SETTLE = 2'd2, S_HOLD = 2'd3;

   int lim_c, run_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_c <= 0;
         run_c <= 0;
      end else begin
         if (state_q == S_RUN && sleep_req) lim_c <= 1 << (int'(settle_sel) + BASE_SHIFT);
         run_c <= (state_q == S_SETTLE) ? run_c + 1 : 0;
      end
   end

   AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RUN && sleep_req) |=> !clk_en); // R1
   AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RUN && $past(state_q) == S_SETTLE) |-> run_c == lim_c); // R2
   AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |=> !wake_valid); // R3
   AST_WAKE_CLK_ON: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> clk_en); // R3
   AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_valid && wake_cause[1]) |-> $past(state_q) == S_HOLD); // R8
   AST_ABORT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      dma_abort |-> $past(sleep_req && dma_busy)); // R10
endmodule

bind standby_wakeup_seq swu_chk #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_chk (
   .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .dma_busy(dma_busy),
   .settle_sel(settle_sel), .clk_en(clk_en), .dma_abort(dma_abort),
   .wake_valid(wake_valid), .wake_cause(wake_cause), .state_q(state_q));

// File: tb/standby_wakeup_seq_tb.sv
`timescale 1ns/1ps
module standby_wakeup_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_req = 1'b0, dma_busy = 1'b0;
   logic [2:0]  settle_sel = 3'd0;
   logic        nmi_pin = 1'b1, nmi_rise = 1'b0;
   logic [3:0]  irq_pin = 4'd0;
   logic [15:0] irq_prio = 16'd0;
   logic [3:0]  cpu_mask = 4'd0;
   logic        por_n = 1'b1, mres_n = 1'b1;
   logic        clk_en, dma_abort, wake_valid;
   logic [1:0]  wake_cause;
   logic [1:0]  wake_irq_id;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   standby_wakeup_seq u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .dma_busy(dma_busy),
      .settle_sel(settle_sel), .nmi_pin(nmi_pin), .nmi_rise(nmi_rise),
      .irq_pin(irq_pin), .irq_prio(irq_prio), .cpu_mask(cpu_mask),
      .por_n(por_n), .mres_n(mres_n), .clk_en(clk_en), .dma_abort(dma_abort),
      .wake_valid(wake_valid), .wake_cause(wake_cause), .wake_irq_id(wake_irq_id));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: m_st 0 run, 1 standby, 2 settle, 3 reset hold
   int m_st, m_cnt, m_lim, m_cause, m_id;
   bit m_wv, m_ab;
   bit n1, n2, np, p1, p2, r1, r2;
   bit [3:0] i1, i2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_lim = 64; m_cause = 0; m_id = 0;
         m_wv = 0; m_ab = 0;
         n1 = 0; n2 = 0; np = 0; i1 = 0; i2 = 0;
         p1 = 1; p2 = 1; r1 = 1; r2 = 1;
      end else begin
         int best, bp;
         m_wv = 0; m_ab = 0;
         best = -1; bp = 0;
         for (int i = 0; i < 4; i++) begin
            int pr;
            pr = int'(irq_prio[i*4 +: 4]);
            if (i2[i] && pr > int'(cpu_mask) && (best < 0 || pr > bp)) begin
               best = i; bp = pr;
            end
         end
         case (m_st)
            0: if (sleep_req) begin
                  m_st = 1; m_lim = 1 << (int'(settle_sel) + 6); m_ab = dma_busy;
               end
            1: if (!p2 || !r2) begin
                  m_st = 3; m_cause = !p2 ? 2 : 3;
               end else if (nmi_rise ? (n2 && !np) : (!n2 && np)) begin
                  m_st = 2; m_cause = 0; m_cnt = 0;
               end else if (best >= 0) begin
                  m_st = 2; m_cause = 1; m_id = best; m_cnt = 0;
               end
            2: if (!p2 || !r2) begin
                  m_st = 3; m_cause = !p2 ? 2 : 3;
               end else if (m_cnt == m_lim - 1) begin
                  m_st = 0; m_wv = 1;
               end else m_cnt++;
            default: begin
               if (!p2) m_cause = 2;
               if (p2 && r2) begin m_st = 0; m_wv = 1; end
            end
         endcase
         np = n2; n2 = n1; n1 = nmi_pin;
         i2 = i1; i1 = irq_pin;
         p2 = p1; p1 = por_n;
         r2 = r1; r1 = mres_n;
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(clk_en == (m_st == 0 || m_st == 3), "R1 clk_en", clk_en, (m_st == 0 || m_st == 3));
         chk(dma_abort == m_ab, "R10 dma_abort", dma_abort, m_ab);
         chk(wake_valid == m_wv, "R3 wake_valid", wake_valid, m_wv);
         if (m_wv) begin
            chk(int'(wake_cause) == m_cause, "R3 wake_cause", wake_cause, m_cause);
            if (m_cause == 1) chk(int'(wake_irq_id) == m_id, "R6 wake_irq_id", wake_irq_id, m_id);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sleep_now(input logic [2:0] sel, input logic busy);
      @(negedge clk);
      sleep_req = 1'b1; settle_sel = sel; dma_busy = busy;
      @(negedge clk);
      sleep_req = 1'b0; dma_busy = 1'b0;
      chk(clk_en == 1'b0, "R1 gated after sleep", clk_en, 0);
      chk(dma_abort == busy, "R10 abort on entry", dma_abort, busy);
   endtask

   task automatic wait_wake(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!wake_valid && n < 20000);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      cyc(3);
      rst_n = 1'b1;
      cyc(3);
      chk(clk_en == 1'b1, "R11 reset clk_en", clk_en, 1);
      chk(wake_valid == 1'b0, "R11 reset wake_valid", wake_valid, 0);
      chk(dma_abort == 1'b0, "R11 reset dma_abort", dma_abort, 0);

      // R4/R2/R10: falling NMI, shortest settle, DMA busy on entry
      sleep_now(3'd0, 1'b1);
      cyc(5);
      nmi_pin = 1'b0;
      wait_wake(n);
      chk(n == 3 + 64, "R2 NMI latency k=0", n, 67);
      chk(wake_cause == 2'd0, "R3 NMI cause", wake_cause, 0);

      // R4: wrong edge ignored, then rising edge with k=2
      nmi_rise = 1'b1;
      nmi_pin = 1'b1;
      cyc(5);
      sleep_now(3'd2, 1'b0);
      nmi_pin = 1'b0;
      cyc(100);
      chk(clk_en == 1'b0, "R4 wrong edge ignored", clk_en, 0);
      nmi_pin = 1'b1;
      wait_wake(n);
      chk(n == 3 + 256, "R4 rising NMI latency k=2", n, 259);

      // R5: masked IRQ, equal-level IRQ, then unmasked
      irq_prio = 16'h0003;
      cpu_mask = 4'd5;
      sleep_now(3'd1, 1'b0);
      irq_pin = 4'b0001;
      cyc(300);
      chk(clk_en == 1'b0, "R5 below mask ignored", clk_en, 0);
      cpu_mask = 4'd3;
      cyc(50);
      chk(clk_en == 1'b0, "R5 equal mask ignored", clk_en, 0);
      cpu_mask = 4'd2;
      wait_wake(n);
      chk(n == 1 + 128, "R5 IRQ latency after unmask", n, 129);
      chk(wake_cause == 2'd1, "R5 IRQ cause", wake_cause, 1);
      irq_pin = 4'd0;
      cpu_mask = 4'd0;
      cyc(5);

      // R6: tie at the highest priority goes to lowest index
      irq_prio = 16'h6640;
      sleep_now(3'd0, 1'b0);
      irq_pin = 4'b1110;
      wait_wake(n);
      chk(n == 67, "R6 IRQ latency", n, 67);
      chk(wake_irq_id == 2'd2, "R6 winner index", wake_irq_id, 2);
      irq_pin = 4'd0;
      cyc(5);

      // R7: NMI and IRQ together
      nmi_rise = 1'b0;
      sleep_now(3'd0, 1'b0);
      nmi_pin = 1'b0;
      irq_pin = 4'b1000;
      wait_wake(n);
      chk(wake_cause == 2'd0, "R7 NMI beats IRQ", wake_cause, 0);
      irq_pin = 4'd0;
      cyc(5);

      // R8: power-on reset during SETTLE
      nmi_rise = 1'b1;
      sleep_now(3'd3, 1'b0);
      nmi_pin = 1'b1;
      cyc(20);
      por_n = 1'b0;
      cyc(2);
      chk(clk_en == 1'b0, "R8 sync delay", clk_en, 0);
      cyc(1);
      chk(clk_en == 1'b1, "R8 clock on in hold", clk_en, 1);
      cyc(40);
      chk(wake_valid == 1'b0, "R8 held while low", wake_valid, 0);
      por_n = 1'b1;
      wait_wake(n);
      chk(n == 3, "R8 release latency", n, 3);
      chk(wake_cause == 2'd2, "R8 POR cause", wake_cause, 2);
      cyc(5);

      // R9: manual reset alone, sleep_req ignored during hold
      sleep_now(3'd0, 1'b0);
      mres_n = 1'b0;
      cyc(20);
      chk(clk_en == 1'b1, "R9 clock on in hold", clk_en, 1);
      sleep_req = 1'b1;
      cyc(1);
      sleep_req = 1'b0;
      mres_n = 1'b1;
      wait_wake(n);
      chk(n == 3, "R9 release latency", n, 3);
      chk(wake_cause == 2'd3, "R9 MRES cause", wake_cause, 3);
      cyc(5);

      // R9: POR seen during a manual-reset hold upgrades the cause
      sleep_now(3'd0, 1'b0);
      mres_n = 1'b0;
      cyc(10);
      por_n = 1'b0;
      cyc(10);
      mres_n = 1'b1;
      por_n = 1'b1;
      wait_wake(n);
      chk(wake_cause == 2'd2, "R9 POR overrides MRES", wake_cause, 2);
      cyc(10);
      chk(clk_en == 1'b1, "R1 running after wake", clk_en, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule